// File: doc/BRIEF.md
# Fan Tachometer Sampling Scheduler

This block decides when a fan's tachometer reading is refreshed while the fan is driven by a low-side PWM signal. The tachometer can only be trusted while the fan is powered, so edges are watched only during the PWM on phase. Each on phase starts with a guard delay that lets the tach signal settle. A reading is the number of time-base ticks between two consecutive tach rising edges. The time base is a one-cycle strobe at about 90 kHz.

An option byte selects the refresh interval, the guard delay and an opportunistic mode. With opportunistic mode on, every valid reading is written at once and restarts the interval timer. With it off, exactly one reading is written per interval, taken from the freshest measurement. If an interval ends with no valid measurement, the block raises a stretch request that the PWM generator uses to hold the output on. The request drops when a measurement completes, or after a bounded number of ticks. In the second case an all-ones "stalled" value is written. A sticky lock freezes the option byte until reset.

The measurement engine has four states. IDLE goes to GUARD on an on-phase rising edge. GUARD goes to ARM after the guard tick count. ARM goes to MEAS on the first tach rising edge. MEAS stays in MEAS, capturing on each further edge. Any state returns to IDLE when the effective PWM is off. The scheduler has two states. RUN goes to STRETCH when an interval expires with nothing fresh. STRETCH goes back to RUN when a capture arrives or the stretch time runs out.

Top module: `fan_tach_sched`

## Requirements
- R1: After reset `opt_q` is 0Ch, `reading` is 0, and `stretch_req` and `reading_vld` are low.
- R2: A write with `opt_wr` high stores `opt_wdata[5:0]`, and `opt_q[7:6]` always read as zero. Field layout: [1:0] interval select, [2] snap-to-zero (stored only), [4:3] guard select, [5] opportunistic enable.
- R3: Once `lock` has been seen high, option writes are ignored until reset, even after `lock` returns low.
- R4: Tach edges are ignored for the first G ticks of each on phase. G is 63, 32, 16 or 8 for guard select 00, 01, 10, 11.
- R5: A valid reading is the number of ticks sampled strictly between the cycles of two consecutive tach rising edges within one on phase after the guard. The count saturates at all ones (stalled).
- R6: Tach edges while the effective PWM (`pwm_in` OR `stretch_req`) is low never produce a reading. A falling on phase abandons any measurement in progress.
- R7: The interval is T_LONG ticks for select 00, T_MID for 01, and T_SHORT for 1x.
- R8: With opportunistic mode off, exactly one write occurs per interval, at its expiry, carrying the latest valid measurement.
- R9: With opportunistic mode on, each valid measurement is written immediately and restarts the interval timer.
- R10: An interval expiring with no fresh measurement raises `stretch_req`. The next valid measurement is written and drops it in the same cycle.
- R11: A stretch that lasts STRETCH_TICKS ticks without a measurement ends by writing all ones and dropping `stretch_req`.
- R12: `reading_vld` is a one-cycle pulse coincident with each update of `reading`, and it is never high while `stretch_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe (~90 kHz) |
| pwm_in | input | 1 | Raw PWM output, high = fan powered |
| tach_in | input | 1 | Synchronised tachometer input |
| opt_wr | input | 1 | Option byte write strobe |
| opt_wdata | input | 8 | Option byte write data |
| lock | input | 1 | Lock request (sticky until reset) |
| opt_q | output | 8 | Current option byte |
| stretch_req | output | 1 | Request to hold PWM on |
| reading | output | CNT_W | Tach reading register |
| reading_vld | output | 1 | Pulse on each reading update |

## Verification
The bench drives periodic tach pulses during a steady on phase in both scheduling modes. This separates immediate opportunistic writes (gap equal to the tach period) from once-per-interval writes (gap equal to the selected interval). Tach pulses with the PWM off show that off-phase edges are rejected and that a stretch is needed to obtain a reading. A silent tach during a stretch exercises the timeout value and its duration. A single long gap between two edges exercises saturation. A section with a sparse tick pattern runs against the behavioural reference model, which separates tick counting from clock counting.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int OPT_W = 8;

    typedef enum logic [1:0] {
        M_IDLE,
        M_GUARD,
        M_ARM,
        M_MEAS
    } meas_st_e;

    typedef enum logic {
        S_RUN,
        S_STRETCH
    } sched_st_e;

    function automatic logic [5:0] guard_ticks(input logic [1:0] sel);
        logic [5:0] n;
        unique case (sel)
            2'b00: n = 6'd63;
            2'b01: n = 6'd32;
            2'b10: n = 6'd16;
            2'b11: n = 6'd8;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/fts_optreg.sv
module fts_optreg #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = 8'h0C,
    parameter logic [W-1:0] WR_MASK = 8'h3F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         lock,
    output logic [W-1:0] opt_q
);
    logic locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q    <= RST_VAL;
            locked_q <= 1'b0;
        end else begin
            if (lock)
                locked_q <= 1'b1;
            if (wr && !lock && !locked_q)
                opt_q <= wdata & WR_MASK;
        end
    end

    // R3
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(opt_q));
endmodule

// File: rtl/fts_measure.sv
module fts_measure #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwm_eff,
    input  logic             tach_in,
    input  logic [1:0]       guard_sel,
    output logic             cap_vld,
    output logic [CNT_W-1:0] cap_val
);
    import fts_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_st_e         st, st_nx;
    logic             pwm_d, tach_d;
    logic [5:0]       gcnt;
    logic [CNT_W-1:0] pcnt;
    logic             pwm_rise, tach_rise;
    logic [5:0]       glen;

    assign pwm_rise  = pwm_eff && !pwm_d;
    assign tach_rise = tach_in && !tach_d;
    assign glen      = guard_ticks(guard_sel);
    assign cap_vld   = (st == M_MEAS) && tach_rise && pwm_eff;
    assign cap_val   = pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= M_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            M_IDLE:  if (pwm_rise) st_nx = M_GUARD;
            M_GUARD: if (tick && (gcnt == glen - 6'd1)) st_nx = M_ARM;
            M_ARM:   if (tach_rise) st_nx = M_MEAS;
            M_MEAS:  st_nx = M_MEAS;
        endcase
        if (!pwm_eff)
            st_nx = M_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_d  <= 1'b0;
            tach_d <= 1'b0;
            gcnt   <= '0;
            pcnt   <= '0;
        end else begin
            pwm_d  <= pwm_eff;
            tach_d <= tach_in;
            if (st != M_GUARD)
                gcnt <= '0;
            else if (tick)
                gcnt <= gcnt + 6'd1;
            if (tach_rise && pwm_eff && (st == M_ARM || st == M_MEAS))
                pcnt <= '0;
            else if (st == M_MEAS && tick && pcnt != CNT_MAX)
                pcnt <= pcnt + 1'b1;
        end
    end

    // R4
    guard_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_IDLE) |=> (st == M_IDLE || st == M_GUARD));
    // R6
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_eff |=> (st == M_IDLE));
    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_MEAS && pcnt == CNT_MAX && !tach_rise && pwm_eff) |=> (pcnt == CNT_MAX));
endmodule

// File: rtl/fts_sched.sv
module fts_sched #(
    parameter int CNT_W         = 16,
    parameter int T_LONG        = 90000,
    parameter int T_MID         = 45000,
    parameter int T_SHORT       = 27000,
    parameter int STRETCH_TICKS = 9000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       updt_sel,
    input  logic             opp_en,
    input  logic             cap_vld,
    input  logic [CNT_W-1:0] cap_val,
    output logic             stretch_q,
    output logic [CNT_W-1:0] reading_q,
    output logic             vld_q
);
    import fts_pkg::*;

    localparam int TMAX  = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                            : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
    localparam int ITV_W = $clog2(TMAX + 1);
    localparam int STR_W = $clog2(STRETCH_TICKS + 1);
    localparam logic [STR_W-1:0] STR_LAST = STR_W'(STRETCH_TICKS - 1);

    sched_st_e        st, st_nx;
    logic [ITV_W-1:0] itv, itv_nx, itv_len;
    logic [STR_W-1:0] stc, stc_nx;
    logic             fresh, fresh_nx, wr_nx;
    logic [CNT_W-1:0] last, last_nx, rd_nx;

    always_comb begin
        case (updt_sel)
            2'b00:   itv_len = ITV_W'(T_LONG);
            2'b01:   itv_len = ITV_W'(T_MID);
            default: itv_len = ITV_W'(T_SHORT);
        endcase
    end

    assign stretch_q = (st == S_STRETCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx    = st;
        itv_nx   = itv;
        stc_nx   = stc;
        fresh_nx = fresh;
        last_nx  = last;
        rd_nx    = reading_q;
        wr_nx    = 1'b0;
        unique case (st)
            S_RUN: begin
                if (cap_vld && opp_en) begin
                    rd_nx    = cap_val;
                    wr_nx    = 1'b1;
                    itv_nx   = '0;
                    fresh_nx = 1'b0;
                end else begin
                    fresh_nx = fresh | cap_vld;
                    last_nx  = cap_vld ? cap_val : last;
                    if (tick) begin
                        if (itv >= itv_len - ITV_W'(1)) begin
                            itv_nx = '0;
                            if (fresh_nx) begin
                                rd_nx    = last_nx;
                                wr_nx    = 1'b1;
                                fresh_nx = 1'b0;
                            end else begin
                                st_nx  = S_STRETCH;
                                stc_nx = '0;
                            end
                        end else begin
                            itv_nx = itv + ITV_W'(1);
                        end
                    end
                end
            end
            S_STRETCH: begin
                if (cap_vld) begin
                    rd_nx    = cap_val;
                    wr_nx    = 1'b1;
                    st_nx    = S_RUN;
                    itv_nx   = '0;
                    fresh_nx = 1'b0;
                end else if (tick) begin
                    if (stc >= STR_LAST) begin
                        rd_nx  = '1;
                        wr_nx  = 1'b1;
                        st_nx  = S_RUN;
                        itv_nx = '0;
                    end else begin
                        stc_nx = stc + STR_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itv       <= '0;
            stc       <= '0;
            fresh     <= 1'b0;
            last      <= '0;
            reading_q <= '0;
            vld_q     <= 1'b0;
        end else begin
            itv       <= itv_nx;
            stc       <= stc_nx;
            fresh     <= fresh_nx;
            last      <= last_nx;
            reading_q <= rd_nx;
            vld_q     <= wr_nx;
        end
    end

    // R10
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STRETCH && cap_vld) |=> (st == S_RUN && vld_q && reading_q == $past(cap_val)));
    // R11
    stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stc <= STR_LAST);
    // R9
    opp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && cap_vld && opp_en) |=> (itv == '0 && vld_q));
    // R12
    vld_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> !stretch_q);
endmodule

// File: rtl/fan_tach_sched.sv
module fan_tach_sched #(
    parameter int CNT_W         = 16,
    parameter int T_LONG        = 90000,
    parameter int T_MID         = 45000,
    parameter int T_SHORT       = 27000,
    parameter int STRETCH_TICKS = 9000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwm_in,
    input  logic             tach_in,
    input  logic             opt_wr,
    input  logic [7:0]       opt_wdata,
    input  logic             lock,
    output logic [7:0]       opt_q,
    output logic             stretch_req,
    output logic [CNT_W-1:0] reading,
    output logic             reading_vld
);
    logic             pwm_eff;
    logic             cap_vld;
    logic [CNT_W-1:0] cap_val;

    assign pwm_eff = pwm_in | stretch_req;

    fts_optreg #(.W(8), .RST_VAL(8'h0C), .WR_MASK(8'h3F)) u_opt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (opt_wr),
        .wdata (opt_wdata),
        .lock  (lock),
        .opt_q (opt_q)
    );

    fts_measure #(.CNT_W(CNT_W)) u_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pwm_eff   (pwm_eff),
        .tach_in   (tach_in),
        .guard_sel (opt_q[4:3]),
        .cap_vld   (cap_vld),
        .cap_val   (cap_val)
    );

    fts_sched #(
        .CNT_W(CNT_W), .T_LONG(T_LONG), .T_MID(T_MID),
        .T_SHORT(T_SHORT), .STRETCH_TICKS(STRETCH_TICKS)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .updt_sel  (opt_q[1:0]),
        .opp_en    (opt_q[5]),
        .cap_vld   (cap_vld),
        .cap_val   (cap_val),
        .stretch_q (stretch_req),
        .reading_q (reading),
        .vld_q     (reading_vld)
    );
endmodule

// File: tb/fan_tach_sched_tb.sv
`timescale 1ns/1ps
module fan_tach_sched_tb;
    localparam int CW = 10;
    localparam int TL = 2000;
    localparam int TM = 1000;
    localparam int TS = 600;
    localparam int ST = 900;
    localparam int ALL1 = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic pwm_in = 1'b0;
    logic tach_in = 1'b0;
    logic opt_wr = 1'b0;
    logic [7:0] opt_wdata = 8'h00;
    logic lock = 1'b0;
    logic [7:0] opt_q;
    logic stretch_req;
    logic [CW-1:0] reading;
    logic reading_vld;

    always #2.5 clk = ~clk;

    fan_tach_sched #(.CNT_W(CW), .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .STRETCH_TICKS(ST)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in), .tach_in(tach_in),
        .opt_wr(opt_wr), .opt_wdata(opt_wdata), .lock(lock), .opt_q(opt_q),
        .stretch_req(stretch_req), .reading(reading), .reading_vld(reading_vld)
    );

    int checks = 0, fails = 0;
    int cycle = 0;
    int vld_cnt = 0, last_vld_cyc = 0, vld_gap = 0, vld_run = 0, vld_run_max = 0;
    int tper = 0, tph = 0;
    bit tach_level = 1'b0, alt_tick = 1'b0, done = 1'b0;

    // behavioural reference model
    int m_cfg, m_locked, m_ph, m_g, m_p, m_pd, m_td, m_itv, m_stc, m_str, m_fresh, m_last, m_rd, m_vld;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 'h0C; m_locked = 0; m_ph = 0; m_g = 0; m_p = 0; m_pd = 0; m_td = 0;
            m_itv = 0; m_stc = 0; m_str = 0; m_fresh = 0; m_last = 0; m_rd = 0; m_vld = 0;
        end else begin
            int peff, prise, trise, glen, cap, capv, ilen, opp;
            int nph, ng, np, nitv, nstc, nstr, nfresh, nlast, nrd, nvld, ncfg;
            peff  = (pwm_in || m_str) ? 1 : 0;
            prise = (peff == 1 && m_pd == 0) ? 1 : 0;
            trise = (tach_in && m_td == 0) ? 1 : 0;
            case ((m_cfg >> 3) & 3)
                0: glen = 63;
                1: glen = 32;
                2: glen = 16;
                default: glen = 8;
            endcase
            case (m_cfg & 3)
                0: ilen = TL;
                1: ilen = TM;
                default: ilen = TS;
            endcase
            opp  = (m_cfg >> 5) & 1;
            cap  = (m_ph == 3 && trise == 1 && peff == 1) ? 1 : 0;
            capv = m_p;
            nph = m_ph;
            if (m_ph == 0 && prise == 1) nph = 1;
            else if (m_ph == 1 && tick && m_g == glen - 1) nph = 2;
            else if (m_ph == 2 && trise == 1) nph = 3;
            if (peff == 0) nph = 0;
            ng = (m_ph != 1) ? 0 : (tick ? m_g + 1 : m_g);
            np = m_p;
            if (trise == 1 && peff == 1 && m_ph >= 2) np = 0;
            else if (m_ph == 3 && tick && m_p < ALL1) np = m_p + 1;
            nitv = m_itv; nstc = m_stc; nstr = m_str; nfresh = m_fresh; nlast = m_last;
            nrd = m_rd; nvld = 0;
            if (m_str == 0) begin
                if (cap == 1 && opp == 1) begin
                    nrd = capv; nvld = 1; nitv = 0; nfresh = 0;
                end else begin
                    if (cap == 1) begin nfresh = 1; nlast = capv; end
                    if (tick) begin
                        if (m_itv >= ilen - 1) begin
                            nitv = 0;
                            if (nfresh == 1) begin nrd = nlast; nvld = 1; nfresh = 0; end
                            else begin nstr = 1; nstc = 0; end
                        end else nitv = m_itv + 1;
                    end
                end
            end else begin
                if (cap == 1) begin
                    nrd = capv; nvld = 1; nstr = 0; nitv = 0; nfresh = 0;
                end else if (tick) begin
                    if (m_stc >= ST - 1) begin nrd = ALL1; nvld = 1; nstr = 0; nitv = 0; end
                    else nstc = m_stc + 1;
                end
            end
            ncfg = m_cfg;
            if (opt_wr && !lock && m_locked == 0) ncfg = opt_wdata & 'h3F;
            if (lock) m_locked = 1;
            m_cfg = ncfg; m_ph = nph; m_g = ng; m_p = np; m_pd = peff; m_td = tach_in ? 1 : 0;
            m_itv = nitv; m_stc = nstc; m_str = nstr; m_fresh = nfresh; m_last = nlast;
            m_rd = nrd; m_vld = nvld;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cycle++;
        if (rst_n) begin
            chk(opt_q == 8'(m_cfg), "R2 option byte vs model", opt_q, m_cfg);
            chk(reading == CW'(m_rd), "R5 reading vs model", reading, m_rd);
            chk(reading_vld == m_vld[0], "R12 reading_vld vs model", reading_vld, m_vld);
            chk(stretch_req == m_str[0], "R10 stretch_req vs model", stretch_req, m_str);
        end
        if (reading_vld) begin
            vld_cnt++;
            vld_gap = cycle - last_vld_cyc;
            last_vld_cyc = cycle;
            vld_run++;
            if (vld_run > vld_run_max) vld_run_max = vld_run;
        end else vld_run = 0;
        tick = alt_tick ? ~tick : 1'b1;
        if (tper > 0) begin
            tph = (tph + 1) % tper;
            tach_in = (tph == 0);
        end else tach_in = tach_level;
    endtask

    task automatic wr_opt(input logic [7:0] v);
        opt_wr = 1'b1; opt_wdata = v;
        cyc();
        opt_wr = 1'b0;
    endtask

    task automatic wait_vld(input int lim, input string req);
        bit got = 1'b0;
        for (int i = 0; i < lim && !got; i++) begin
            cyc();
            if (reading_vld) got = 1'b1;
        end
        chk(got, req, got, 1);
    endtask

    task automatic wait_stretch(input int lim, input string req);
        bit got = 1'b0;
        for (int i = 0; i < lim && !got; i++) begin
            cyc();
            if (stretch_req) got = 1'b1;
        end
        chk(got, req, got, 1);
    endtask

    initial begin
        for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int rise_cyc, len;
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk(opt_q == 8'h0C, "R1 opt_q after reset", opt_q, 'h0C);
        chk(reading == '0, "R1 reading after reset", reading, 0);
        chk(!stretch_req, "R1 stretch_req after reset", stretch_req, 0);
        chk(!reading_vld, "R1 reading_vld after reset", reading_vld, 0);
        // R2 reserved bits
        wr_opt(8'hFF); cyc();
        chk(opt_q == 8'h3F, "R2 reserved bits read zero", opt_q, 'h3F);
        wr_opt(8'h3C); cyc();
        chk(opt_q == 8'h3C, "R2 write stored", opt_q, 'h3C);
        // R6 off-phase edges ignored
        tper = 20; vld_cnt = 0;
        repeat (500) cyc();
        chk(vld_cnt == 0, "R6 no update with PWM off", vld_cnt, 0);
        chk(reading == '0, "R6 reading unchanged with PWM off", reading, 0);
        // R4 guard 63, R9 opportunistic, R5 period
        wr_opt(8'h24);
        pwm_in = 1'b1; rise_cyc = cycle;
        wait_vld(300, "R4 first reading after guard");
        chk(last_vld_cyc - rise_cyc > 63, "R4 first reading later than guard", last_vld_cyc - rise_cyc, 64);
        chk(reading == CW'(19), "R5 period reading", reading, 19);
        wait_vld(100, "R9 second opportunistic reading");
        chk(vld_gap == 20, "R9 immediate write per measurement", vld_gap, 20);
        // R7 / R8 non-opportunistic intervals
        wr_opt(8'h0D);
        wait_vld(1200, "R8 first interval update");
        wait_vld(1200, "R8 second interval update");
        chk(vld_gap == TM, "R7 interval select 01", vld_gap, TM);
        chk(reading == CW'(19), "R8 latest measurement written", reading, 19);
        vld_cnt = 0;
        repeat (2500) cyc();
        chk(vld_cnt == 2, "R8 one update per interval", vld_cnt, 2);
        wr_opt(8'h0E);
        wait_vld(1200, "R7 update after select 1x");
        wait_vld(800, "R7 second update select 1x");
        chk(vld_gap == TS, "R7 interval select 1x", vld_gap, TS);
        // R10 stretch obtains a reading
        wr_opt(8'h3C);
        pwm_in = 1'b0;
        wait_stretch(2200, "R10 stretch raised on stale expiry");
        wait_vld(300, "R10 reading during stretch");
        chk(reading == CW'(19), "R10 stretched reading", reading, 19);
        chk(!stretch_req, "R10 stretch dropped with write", stretch_req, 0);
        // R11 stretch timeout
        tper = 0; tach_level = 1'b0;
        wait_stretch(2200, "R11 stretch raised");
        len = 1;
        while (stretch_req && len < 2000) begin cyc(); if (stretch_req) len++; end
        chk(len == ST, "R11 stretch duration", len, ST);
        chk(reading_vld, "R11 timeout write pulse", reading_vld, 1);
        chk(reading == CW'(ALL1), "R11 timeout writes all ones", reading, ALL1);
        // R5 saturation
        pwm_in = 1'b1; tper = 20;
        repeat (100) cyc();
        tper = 0; tach_level = 1'b0;
        repeat (3) cyc();
        tach_level = 1'b1; cyc(); tach_level = 1'b0;
        repeat (1500) cyc();
        tach_level = 1'b1; cyc(); tach_level = 1'b0;
        wait_vld(10, "R5 saturated capture");
        chk(reading == CW'(ALL1), "R5 saturated count", reading, ALL1);
        // sparse tick pattern, model comparison only
        alt_tick = 1'b1; tper = 20;
        repeat (3000) cyc();
        pwm_in = 1'b0;
        repeat (3000) cyc();
        alt_tick = 1'b0;
        // R12 pulse width
        chk(vld_run_max == 1, "R12 single-cycle pulse", vld_run_max, 1);
        // R3 sticky lock
        lock = 1'b1; cyc(); lock = 1'b0;
        wr_opt(8'h00); cyc();
        chk(opt_q == 8'h3C, "R3 write ignored while locked", opt_q, 'h3C);
        wr_opt(8'h11); cyc();
        chk(opt_q == 8'h3C, "R3 lock stays after release", opt_q, 'h3C);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule